// File: doc/BRIEF.md
# Multiply, Accumulate and Divide Coprocessor

This unit sits next to a 16-bit processor core and takes arithmetic that the core would otherwise do slowly. A 7-bit mode word, written with a strobe, names the operation that the next start pulse runs and which half of the shared 32-bit result register drives the 16-bit read port. Start carries two 16-bit arguments. Multiply, multiply-accumulate and the small housekeeping operations finish in one clock. Division runs a restoring shift-subtract engine over several clocks, and busy stays high until the quotient and remainder land in the result register.

The core reads a 32-bit result in two 16-bit accesses. It writes the mode word with the other output half selected between the reads. Two sticky flags report accumulate overflow and division by zero.

Top module: `arith_coproc`

## Requirements
- R1: After reset the result register, both flags, busy and done are 0, and the mode word is 0, so the read port shows the low half of the result.
- R2: A mode write stores modeIn. Bits 3:0 are the operation code and bits 6:4 the output select. Output select 1 puts result bits 31:16 on resOut, and every other value puts bits 15:0 there. A mode write clears both flags.
- R3: Operation 0 clears the result and both flags. Operation 1 loads the result with {argA, argB}, with argA as the high half. Every accepted single-cycle operation updates the result on the start edge and pulses done for one cycle right after that edge.
- R4: Operation 2 writes the unsigned 32-bit product of argA and argB. Operation 3 writes the two's-complement signed product. Both take one cycle.
- R5: Operation 6 adds the signed product to the result register, wrapping modulo 2^32. flagOut[0] is set when the true signed sum falls outside the 32-bit range, and it stays set until a mode write or operation 0.
- R6: Operation 4 divides unsigned. It leaves the quotient in result bits 15:0 and the remainder in bits 31:16. Counting the start edge as edge 1, the result is written, done pulses and busy falls after edge 17.
- R7: Operation 5 divides signed. The quotient is truncated toward zero, and the remainder is zero or carries the dividend's sign. The latency is 18 edges, plus 1 if the operand signs differ, plus 1 if the dividend is negative. -32768 / -1 yields quotient 0x8000 and remainder 0.
- R8: With a zero divisor, in either divide mode, the divide takes 17 edges. It returns quotient 0xFFFF and a remainder equal to the raw dividend, and sets flagOut[1]. flagOut[1] stays set until a mode write or operation 0.
- R9: While busy is high, start and mode writes are ignored, and the result register keeps its old value until the divide writes it.
- R10: Operation 7 loads the result with the flags, {30'b0, flagOut[1], flagOut[0]}. Operation 8 and the reserved codes 9 to 15 change nothing but still pulse done.
- R11: When a mode write and start arrive in the same cycle, the mode write takes effect and the start is ignored: no done pulse and no result change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| modeWr | input | 1 | Mode word write strobe |
| modeIn | input | 7 | Mode word: operation code in 3:0, output select in 6:4 |
| start | input | 1 | Runs the current operation on argA and argB |
| argA | input | 16 | First operand, the dividend when dividing |
| argB | input | 16 | Second operand, the divisor when dividing |
| resOut | output | 16 | Selected half of the result register |
| flagOut | output | 2 | Bit 1 divide-by-zero, bit 0 accumulate overflow |
| busy | output | 1 | High while a divide is in progress |
| done | output | 1 | One-cycle pulse when a result has been written |

## Verification
The bench measures divide latency for every sign combination. A divider that ran its fix-up cycles on the wrong condition would show up as a latency off by one or two, or as a remainder with the wrong sign. It also divides -32768 by -1 and divides by zero in both signed and unsigned modes. A bad magnitude conversion or zero-divisor handling would give a wrong quotient or a missing flag there. Accumulations are driven across the positive overflow boundary, and further accumulations follow to catch a flag that does not stick or a sum that does not wrap. The bench pulses start and mode writes in the middle of a divide, and sends both strobes in the same cycle. A control block that accepted either strobe then would clear flags, corrupt the result or raise an extra done.

// File: rtl/arith_coproc_pkg.sv
package arith_coproc_pkg;
  localparam int OP_W = 4;
  localparam int OM_W = 3;
  localparam int MODE_W = OP_W + OM_W;

  localparam logic [OP_W-1:0] OP_CLR   = 4'd0;
  localparam logic [OP_W-1:0] OP_LDACC = 4'd1;
  localparam logic [OP_W-1:0] OP_MULU  = 4'd2;
  localparam logic [OP_W-1:0] OP_MULS  = 4'd3;
  localparam logic [OP_W-1:0] OP_DIVU  = 4'd4;
  localparam logic [OP_W-1:0] OP_DIVS  = 4'd5;
  localparam logic [OP_W-1:0] OP_MAC   = 4'd6;
  localparam logic [OP_W-1:0] OP_FLAGS = 4'd7;

  localparam logic [OM_W-1:0] OM_HIGH = 3'd1;

  // strobes from control to datapath, at most one operation strobe per cycle
  typedef struct packed {
    logic modeWr;
    logic clrAll;
    logic ldAcc;
    logic mulU;
    logic mulS;
    logic mac;
    logic rdFlags;
    logic divInit;
    logic divAbs;
    logic divStep;
    logic divNegQ;
    logic divNegR;
    logic divFinish;
  } dpCtl_t;
endpackage

// File: rtl/arith_coproc_ctrl.sv
module arith_coproc_ctrl
  import arith_coproc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modeWr,
  input  logic            start,
  input  logic [OP_W-1:0] opCode,
  input  logic            sgnA,
  input  logic            sgnB,
  input  logic            dvsZero,
  output dpCtl_t          ctl,
  output logic            busy,
  output logic            done
);
  localparam int CW = $clog2(W);

  typedef enum logic [2:0] {S_IDLE, S_ABS, S_ITER, S_NEGQ, S_NEGR} state_e;

  state_e        state, stateNext;
  logic [CW-1:0] cnt;
  logic          fixQ, fixR;
  logic          accept, isDiv, sgnDiv, lastIter;

  always_comb begin
    accept    = (state == S_IDLE) && start && !modeWr;
    isDiv     = (opCode == OP_DIVU) || (opCode == OP_DIVS);
    sgnDiv    = (opCode == OP_DIVS) && !dvsZero;
    lastIter  = (cnt == CW'(W - 1));
    ctl       = '0;
    stateNext = state;
    ctl.modeWr = modeWr && (state == S_IDLE);
    case (state)
      S_IDLE: begin
        if (accept) begin
          case (opCode)
            OP_CLR:   ctl.clrAll  = 1'b1;
            OP_LDACC: ctl.ldAcc   = 1'b1;
            OP_MULU:  ctl.mulU    = 1'b1;
            OP_MULS:  ctl.mulS    = 1'b1;
            OP_MAC:   ctl.mac     = 1'b1;
            OP_FLAGS: ctl.rdFlags = 1'b1;
            OP_DIVU, OP_DIVS: begin
              ctl.divInit = 1'b1;
              stateNext   = sgnDiv ? S_ABS : S_ITER;
            end
            default: ;
          endcase
        end
      end
      S_ABS: begin
        ctl.divAbs = 1'b1;
        stateNext  = S_ITER;
      end
      S_ITER: begin
        ctl.divStep = 1'b1;
        if (lastIter) begin
          if (fixQ)      stateNext = S_NEGQ;
          else if (fixR) stateNext = S_NEGR;
          else begin
            ctl.divFinish = 1'b1;
            stateNext     = S_IDLE;
          end
        end
      end
      S_NEGQ: begin
        ctl.divNegQ = 1'b1;
        if (fixR) stateNext = S_NEGR;
        else begin
          ctl.divFinish = 1'b1;
          stateNext     = S_IDLE;
        end
      end
      S_NEGR: begin
        ctl.divNegR   = 1'b1;
        ctl.divFinish = 1'b1;
        stateNext     = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      fixQ  <= 1'b0;
      fixR  <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      busy  <= (stateNext != S_IDLE);
      done  <= ctl.divFinish || (accept && !isDiv);
      if (ctl.divInit) begin
        cnt  <= '0;
        fixQ <= sgnDiv && (sgnA ^ sgnB);
        fixR <= sgnDiv && sgnA;
      end else if (ctl.divStep) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R6
  div_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R9
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(start) && !$past(modeWr)));
endmodule

// File: rtl/arith_coproc_dp.sv
module arith_coproc_dp
  import arith_coproc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [MODE_W-1:0] modeIn,
  input  logic [W-1:0]      argA,
  input  logic [W-1:0]      argB,
  output logic [W-1:0]      resOut,
  output logic [1:0]        flagOut,
  output logic [OP_W-1:0]   opCode,
  output logic              sgnA,
  output logic              sgnB,
  output logic              dvsZero
);
  localparam int RW = 2 * W;

  logic [MODE_W-1:0] modeReg;
  logic [RW-1:0]     resReg;
  logic              ovfFlag, dzFlag;
  logic [W-1:0]      remReg, quoReg, dvsReg;

  logic [RW-1:0] prodU, prodS;
  logic [RW:0]   macSum;
  logic [W:0]    shifted, trial;
  logic [W-1:0]  nRem, nQuo;

  function automatic logic [W-1:0] neg(input logic [W-1:0] v);
    return ~v + {{(W-1){1'b0}}, 1'b1};
  endfunction

  assign opCode  = modeReg[OP_W-1:0];
  assign sgnA    = argA[W-1];
  assign sgnB    = argB[W-1];
  assign dvsZero = (argB == '0);
  assign resOut  = (modeReg[MODE_W-1:OP_W] == OM_HIGH) ? resReg[RW-1:W] : resReg[W-1:0];
  assign flagOut = {dzFlag, ovfFlag};

  always_comb begin
    prodU  = {{W{1'b0}}, argA} * {{W{1'b0}}, argB};
    prodS  = $unsigned($signed({{W{argA[W-1]}}, argA}) * $signed({{W{argB[W-1]}}, argB}));
    macSum = {resReg[RW-1], resReg} + {prodS[RW-1], prodS};
    shifted = {remReg, quoReg[W-1]};
    trial   = shifted - {1'b0, dvsReg};
    nRem = remReg;
    nQuo = quoReg;
    if (ctl.divStep) begin
      nRem = trial[W] ? shifted[W-1:0] : trial[W-1:0];
      nQuo = {quoReg[W-2:0], ~trial[W]};
    end else if (ctl.divNegQ) begin
      nQuo = neg(quoReg);
    end else if (ctl.divNegR) begin
      nRem = neg(remReg);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      resReg  <= '0;
      ovfFlag <= 1'b0;
      dzFlag  <= 1'b0;
      remReg  <= '0;
      quoReg  <= '0;
      dvsReg  <= '0;
    end else begin
      if (ctl.modeWr) begin
        modeReg <= modeIn;
        ovfFlag <= 1'b0;
        dzFlag  <= 1'b0;
      end
      if (ctl.clrAll) begin
        resReg  <= '0;
        ovfFlag <= 1'b0;
        dzFlag  <= 1'b0;
      end
      if (ctl.ldAcc)   resReg <= {argA, argB};
      if (ctl.mulU)    resReg <= prodU;
      if (ctl.mulS)    resReg <= prodS;
      if (ctl.rdFlags) resReg <= {{(RW-2){1'b0}}, dzFlag, ovfFlag};
      if (ctl.mac) begin
        resReg <= macSum[RW-1:0];
        if (macSum[RW] != macSum[RW-1]) ovfFlag <= 1'b1;
      end
      if (ctl.divInit) begin
        quoReg <= argA;
        dvsReg <= argB;
        remReg <= '0;
      end
      if (ctl.divAbs) begin
        if (quoReg[W-1]) quoReg <= neg(quoReg);
        if (dvsReg[W-1]) dvsReg <= neg(dvsReg);
      end
      if (ctl.divStep || ctl.divNegQ || ctl.divNegR) begin
        remReg <= nRem;
        quoReg <= nQuo;
      end
      if (ctl.divFinish) begin
        resReg <= {nRem, nQuo};
        if (dvsReg == '0) dzFlag <= 1'b1;
      end
    end
  end

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ctl.modeWr && !ctl.clrAll) |=> ovfFlag);
  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((ctl.divAbs || ctl.divStep || ctl.divNegQ) && !ctl.divFinish) |=> $stable(resReg));
  // R8
  dz_quot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dzFlag) |-> (resReg[W-1:0] == {W{1'b1}}));
endmodule

// File: rtl/arith_coproc.sv
module arith_coproc
  import arith_coproc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWr,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              start,
  input  logic [W-1:0]      argA,
  input  logic [W-1:0]      argB,
  output logic [W-1:0]      resOut,
  output logic [1:0]        flagOut,
  output logic              busy,
  output logic              done
);
  dpCtl_t          ctl;
  logic [OP_W-1:0] opCode;
  logic            sgnA, sgnB, dvsZero;

  arith_coproc_ctrl #(.W(W)) uCtrl (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .start(start),
    .opCode(opCode), .sgnA(sgnA), .sgnB(sgnB), .dvsZero(dvsZero),
    .ctl(ctl), .busy(busy), .done(done)
  );

  arith_coproc_dp #(.W(W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .modeIn(modeIn),
    .argA(argA), .argB(argB), .resOut(resOut), .flagOut(flagOut),
    .opCode(opCode), .sgnA(sgnA), .sgnB(sgnB), .dvsZero(dvsZero)
  );
endmodule

// File: tb/sim_arith_coproc.sv
module sim_arith_coproc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeWr = 1'b0;
  logic [6:0]  modeIn = '0;
  logic        start = 1'b0;
  logic [15:0] argA = '0, argB = '0;
  logic [15:0] resOut;
  logic [1:0]  flagOut;
  logic        busy, done;

  arith_coproc u0 (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeIn(modeIn), .start(start),
    .argA(argA), .argB(argB), .resOut(resOut), .flagOut(flagOut),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [15:0] out;
    logic [1:0]  flg;
    int          lat;
    string       tag;
  } item_t;

  item_t       sbq[$];
  int          checks = 0, errors = 0;
  int          cyc = 0, issueCyc = 0;
  logic [31:0] mRes = '0;
  logic        mOvf = 1'b0, mDz = 1'b0;
  logic [6:0]  mMode = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] selHalf();
    return (mMode[6:4] == 3'd1) ? mRes[31:16] : mRes[15:0];
  endfunction

  // monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R11", "done with nothing pending", 32'(done), 32'd0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(resOut == it.out, it.tag, "resOut", 32'(resOut), 32'(it.out));
        check(flagOut == it.flg, it.tag, "flagOut", 32'(flagOut), 32'(it.flg));
        check((cyc - issueCyc + 1) == it.lat, it.tag, "latency",
              32'(cyc - issueCyc + 1), 32'(it.lat));
      end
    end
  end

  task automatic writeMode(input logic [6:0] m);
    @(negedge clk);
    modeWr = 1'b1;
    modeIn = m;
    @(negedge clk);
    modeWr = 1'b0;
    mMode = m;
    mOvf = 1'b0;
    mDz = 1'b0;
  endtask

  // driver: computes the expected result and pushes it, then pulses start
  task automatic launch(input logic [15:0] a, input logic [15:0] b, input string tag);
    item_t it;
    int sa, sb, ua, ub, q, r, lat;
    longint p, s;
    sa = $signed(a); sb = $signed(b); ua = a; ub = b;
    lat = 1;
    case (mMode[3:0])
      4'd0: begin mRes = '0; mOvf = 1'b0; mDz = 1'b0; end
      4'd1: mRes = {a, b};
      4'd2: mRes = 32'(ua * ub);
      4'd3: mRes = 32'(sa * sb);
      4'd6: begin
        p = longint'(sa) * longint'(sb);
        s = longint'($signed(mRes)) + p;
        if (s > 64'sd2147483647 || s < -64'sd2147483648) mOvf = 1'b1;
        mRes = s[31:0];
      end
      4'd7: mRes = {30'd0, mDz, mOvf};
      4'd4, 4'd5: begin
        if (b == 16'd0) begin
          mRes = {a, 16'hFFFF}; mDz = 1'b1; lat = 17;
        end else if (mMode[3:0] == 4'd4) begin
          q = ua / ub; r = ua % ub; mRes = {r[15:0], q[15:0]}; lat = 17;
        end else begin
          q = sa / sb; r = sa % sb; mRes = {r[15:0], q[15:0]};
          lat = 18 + ((a[15] != b[15]) ? 1 : 0) + (a[15] ? 1 : 0);
        end
      end
      default: ;
    endcase
    it.out = selHalf(); it.flg = {mDz, mOvf}; it.lat = lat; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    start = 1'b1; argA = a; argB = b;
    issueCyc = cyc + 1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    wait (sbq.size() == 0);
    @(negedge clk);
  endtask

  task automatic issue(input logic [15:0] a, input logic [15:0] b, input string tag);
    launch(a, b, tag);
    waitIdle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R6", "watchdog expired", 32'(sbq.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(resOut == 16'd0, "R1", "resOut", 32'(resOut), 32'd0);
    check(flagOut == 2'd0 && !busy && !done, "R1", "flags/busy/done",
          {29'd0, flagOut, busy}, 32'd0);

    // R3 load, low and high halves
    writeMode({3'd0, 4'd1});
    issue(16'h1234, 16'h5678, "R3");
    writeMode({3'd1, 4'd1});
    issue(16'hABCD, 16'h0123, "R3");
    // R2 reserved output select shows the low half; R10 reserved opcode is a no-op
    writeMode({3'd5, 4'd12});
    issue(16'hFFFF, 16'hFFFF, "R2");
    writeMode({3'd1, 4'd8});
    issue(16'h0000, 16'h0001, "R10");
    // R3 clear
    writeMode({3'd1, 4'd0});
    issue(16'h1111, 16'h2222, "R3");

    // R4 multiplies
    writeMode({3'd1, 4'd2});
    issue(16'hFFFF, 16'hFFFF, "R4");
    writeMode({3'd0, 4'd2});
    issue(16'hFFFF, 16'hFFFF, "R4");
    writeMode({3'd0, 4'd3});
    issue(16'hFFFF, 16'hFFFF, "R4");
    writeMode({3'd1, 4'd3});
    issue(16'h8000, 16'h7FFF, "R4");

    // R5 accumulate across the positive limit, then keep accumulating
    writeMode({3'd1, 4'd1});
    issue(16'h7FFF, 16'hFF00, "R5");
    writeMode({3'd1, 4'd6});
    issue(16'h0100, 16'h0001, "R5");
    issue(16'h0001, 16'h0001, "R5");
    issue(16'hFFFF, 16'h0003, "R5");
    writeMode({3'd0, 4'd6});
    issue(16'h0002, 16'h0002, "R5");
    // R10 flag read after a mode write sees cleared flags
    writeMode({3'd0, 4'd7});
    issue(16'h0000, 16'h0000, "R10");

    // R6 unsigned divides
    writeMode({3'd0, 4'd4});
    issue(16'd1000, 16'd7, "R6");
    writeMode({3'd1, 4'd4});
    issue(16'd1000, 16'd7, "R6");
    issue(16'hFFFF, 16'h0001, "R6");

    // R7 signed divides over all sign combinations
    writeMode({3'd0, 4'd5});
    issue(16'd7, 16'd2, "R7");
    issue(16'hFFF9, 16'd2, "R7");
    issue(16'd7, 16'hFFFE, "R7");
    issue(16'hFFF9, 16'hFFFE, "R7");
    issue(16'h8000, 16'hFFFF, "R7");
    writeMode({3'd1, 4'd5});
    issue(16'hFFF9, 16'd2, "R7");
    issue(16'h8000, 16'hFFFF, "R7");

    // R8 divide by zero, signed and unsigned
    issue(16'h8000, 16'h0000, "R8");
    writeMode({3'd0, 4'd4});
    issue(16'd5, 16'd0, "R8");

    // R9 start and mode write during busy are ignored; dz flag must survive
    launch(16'd100, 16'd7, "R9");
    @(negedge clk);
    check(busy == 1'b1, "R9", "busy mid divide", 32'(busy), 32'd1);
    start = 1'b1; argA = 16'd9; argB = 16'd3;
    @(negedge clk);
    start = 1'b0;
    modeWr = 1'b1; modeIn = {3'd1, 4'd0};
    @(negedge clk);
    modeWr = 1'b0;
    check(resOut == 16'hFFFF, "R9", "result held mid divide", 32'(resOut), 32'h0000FFFF);
    waitIdle();

    // R11 simultaneous mode write and start: mode written, start dropped
    @(negedge clk);
    modeWr = 1'b1; modeIn = {3'd1, 4'd1}; start = 1'b1; argA = 16'hDEAD; argB = 16'hBEEF;
    @(negedge clk);
    modeWr = 1'b0; start = 1'b0;
    mMode = {3'd1, 4'd1}; mOvf = 1'b0; mDz = 1'b0;
    repeat (3) @(negedge clk);
    check(resOut == mRes[31:16], "R11", "resOut after dropped start",
          32'(resOut), 32'(mRes[31:16]));
    check(flagOut == 2'd0, "R11", "flags cleared by write", 32'(flagOut), 32'd0);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule